// File: doc/BRIEF.md
# Banked 24-bit Effective Address Generator

This block forms the 24-bit bus address for every memory access of a CPU that has a 16 MB address space. Each access supplies a 16-bit offset: the program counter, a data offset, the direct-page register or the stack pointer. The block places an 8-bit bank above that offset. Which bank is used, and whether a carry out of the low 16 bits may reach it, depends on the kind of access the sequencer reports in the same cycle.

Two bank registers live here. The data bank can be written by the program. The program bank changes only through a dedicated long-jump load. Both registers clear on reset and are visible on output ports.

The address and the penalty-cycle flag are combinational in the current inputs and the stored banks. A bank write takes effect at the next clock edge. The penalty flag asks the sequencer for one extra cycle when a direct-page access starts from a direct-page register that is not page aligned.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset, both the program bank and the data bank read 0x00.
- R2: For kind code 0 (instruction fetch), the address is {program bank, (pcValue + baseOffset) mod 2^16}. A wrap of the 16-bit sum never changes bits 23..16.
- R3: For kind code 1 (absolute data), the address is {data bank, baseOffset}.
- R4: For kind code 2 (indexed data), the address is ({data bank, baseOffset} + indexValue) mod 2^24. A carry past 0xFFFF raises the bank used for that access, and the stored data bank is left unchanged.
- R5: For kind code 3 (long operand), the address is {longBank, baseOffset}, and the data bank has no effect.
- R6: For kind code 4 (direct page), the address is {0x00, (dpReg + baseOffset[7:0]) mod 2^16}.
- R7: For kind code 5 (stack), the address is {0x00, (stackPtr + baseOffset) mod 2^16}.
- R8: penaltyCycle is 1 exactly when the kind code is 4 and dpReg[7:0] is nonzero. Otherwise it is 0.
- R9: A data bank write stores dbWrData at the next rising edge. During the cycle of the write, accesses still use the old value. The program bank changes only through pbLoadEn. Kind codes 6 and 7 give address 0 and no penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accessKind | input | 3 | Access kind code (0 fetch, 1 absolute, 2 indexed, 3 long, 4 direct, 5 stack) |
| baseOffset | input | 16 | Offset or operand for the access |
| indexValue | input | 16 | Index added for indexed data |
| pcValue | input | 16 | Program counter |
| dpReg | input | 16 | Direct-page register |
| stackPtr | input | 16 | Stack pointer |
| longBank | input | 8 | Bank byte of a long operand |
| dbWrEn | input | 1 | Data bank write strobe |
| dbWrData | input | 8 | New data bank value |
| pbLoadEn | input | 1 | Long-jump program bank load strobe |
| pbLoadData | input | 8 | New program bank value |
| busAddr | output | 24 | Effective bus address |
| penaltyCycle | output | 1 | Request for one extra direct-page cycle |
| progBank | output | 8 | Stored program bank |
| dataBank | output | 8 | Stored data bank |

## Verification
A data bank write and an indexed access can occur in the same cycle, and so can a program bank load and a fetch. The bench provokes both. It asserts the write strobe together with an access whose offset carries into the next bank. It then checks that the address seen before the edge uses the old bank plus carry, and that the address seen after the edge uses the new bank. Randomized offsets and indices near 0xFFFF exercise the wrap and carry rule of each access kind against bench reference functions.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int OFFSET_W = 16;
  localparam int BANK_W   = 8;
  localparam int DP_OP_W  = 8;

  typedef enum logic [2:0] {
    KIND_FETCH  = 3'd0,
    KIND_ABS    = 3'd1,
    KIND_INDEX  = 3'd2,
    KIND_LONG   = 3'd3,
    KIND_DIRECT = 3'd4,
    KIND_STACK  = 3'd5
  } accessKind_t;

  typedef struct packed {
    logic selFetch;
    logic selAbs;
    logic selIndex;
    logic selLong;
    logic selDirect;
    logic selStack;
    logic dbWrite;
    logic pbLoad;
  } strobes_t;
endpackage

// File: rtl/eag_control.sv
module eag_control
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] accessKind,
  input  logic       dbWrEn,
  input  logic       pbLoadEn,
  output strobes_t   strobes
);
  always_comb begin
    strobes           = '0;
    strobes.selFetch  = (accessKind == KIND_FETCH);
    strobes.selAbs    = (accessKind == KIND_ABS);
    strobes.selIndex  = (accessKind == KIND_INDEX);
    strobes.selLong   = (accessKind == KIND_LONG);
    strobes.selDirect = (accessKind == KIND_DIRECT);
    strobes.selStack  = (accessKind == KIND_STACK);
    strobes.dbWrite   = dbWrEn;
    strobes.pbLoad    = pbLoadEn;
  end

  // R9: at most one address source is selected per cycle
  assert_selOnehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selFetch, strobes.selAbs, strobes.selIndex,
              strobes.selLong, strobes.selDirect, strobes.selStack}));
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int OFS_W = OFFSET_W,
  parameter int BNK_W = BANK_W,
  parameter int DPO_W = DP_OP_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               strobes,
  input  logic [OFS_W-1:0]       baseOffset,
  input  logic [OFS_W-1:0]       indexValue,
  input  logic [OFS_W-1:0]       pcValue,
  input  logic [OFS_W-1:0]       dpReg,
  input  logic [OFS_W-1:0]       stackPtr,
  input  logic [BNK_W-1:0]       longBank,
  input  logic [BNK_W-1:0]       dbWrData,
  input  logic [BNK_W-1:0]       pbLoadData,
  output logic [OFS_W+BNK_W-1:0] busAddr,
  output logic                   penaltyCycle,
  output logic [BNK_W-1:0]       progBank,
  output logic [BNK_W-1:0]       dataBank
);
  localparam int ADDR_W = OFS_W + BNK_W;

  logic [BNK_W-1:0]  pbQ, dbQ;
  logic [OFS_W-1:0]  fetchOfs, directOfs, stackOfs;
  logic [ADDR_W-1:0] indexAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pbQ <= '0;
      dbQ <= '0;
    end else begin
      if (strobes.pbLoad)  pbQ <= pbLoadData;
      if (strobes.dbWrite) dbQ <= dbWrData;
    end
  end

  // Each sum is kept to its own width, so any wrap stays inside that width.
  always_comb begin
    fetchOfs  = pcValue + baseOffset;
    directOfs = dpReg + {{(OFS_W-DPO_W){1'b0}}, baseOffset[DPO_W-1:0]};
    stackOfs  = stackPtr + baseOffset;
    indexAddr = {dbQ, baseOffset} + {{BNK_W{1'b0}}, indexValue};
  end

  always_comb begin
    busAddr = '0;
    unique case (1'b1)
      strobes.selFetch:  busAddr = {pbQ, fetchOfs};
      strobes.selAbs:    busAddr = {dbQ, baseOffset};
      strobes.selIndex:  busAddr = indexAddr;
      strobes.selLong:   busAddr = {longBank, baseOffset};
      strobes.selDirect: busAddr = {{BNK_W{1'b0}}, directOfs};
      strobes.selStack:  busAddr = {{BNK_W{1'b0}}, stackOfs};
      default:           busAddr = '0;
    endcase
  end

  assign penaltyCycle = strobes.selDirect & (|dpReg[DPO_W-1:0]);
  assign progBank     = pbQ;
  assign dataBank     = dbQ;

  assert_dbHold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.dbWrite |=> $stable(dbQ));
  assert_pbHold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pbLoad |=> $stable(pbQ));
  assert_dbLoad_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dbWrite |=> (dbQ == $past(dbWrData)));
  assert_resetBanks_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pbQ == '0 && dbQ == '0));
  assert_fetchBank_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selFetch |-> (busAddr[ADDR_W-1:OFS_W] == pbQ));
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  accessKind,
  input  logic [15:0] baseOffset,
  input  logic [15:0] indexValue,
  input  logic [15:0] pcValue,
  input  logic [15:0] dpReg,
  input  logic [15:0] stackPtr,
  input  logic [7:0]  longBank,
  input  logic        dbWrEn,
  input  logic [7:0]  dbWrData,
  input  logic        pbLoadEn,
  input  logic [7:0]  pbLoadData,
  output logic [23:0] busAddr,
  output logic        penaltyCycle,
  output logic [7:0]  progBank,
  output logic [7:0]  dataBank
);
  strobes_t strobes;

  eag_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .accessKind (accessKind),
    .dbWrEn     (dbWrEn),
    .pbLoadEn   (pbLoadEn),
    .strobes    (strobes)
  );

  eag_datapath #(.OFS_W(OFFSET_W), .BNK_W(BANK_W), .DPO_W(DP_OP_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .baseOffset   (baseOffset),
    .indexValue   (indexValue),
    .pcValue      (pcValue),
    .dpReg        (dpReg),
    .stackPtr     (stackPtr),
    .longBank     (longBank),
    .dbWrData     (dbWrData),
    .pbLoadData   (pbLoadData),
    .busAddr      (busAddr),
    .penaltyCycle (penaltyCycle),
    .progBank     (progBank),
    .dataBank     (dataBank)
  );

  assert_directBankZero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accessKind == 3'd4) |-> (busAddr[23:16] == 8'h00));
  assert_stackBankZero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accessKind == 3'd5) |-> (busAddr[23:16] == 8'h00));
  assert_penaltyKind_R8: assert property (@(posedge clk) disable iff (!rstN)
    penaltyCycle |-> (accessKind == 3'd4));
  assert_longBank_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accessKind == 3'd3) |-> (busAddr == {longBank, baseOffset}));
endmodule

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  accessKind = 3'd0;
  logic [15:0] baseOffset = '0, indexValue = '0, pcValue = '0;
  logic [15:0] dpReg = '0, stackPtr = '0;
  logic [7:0]  longBank = '0, dbWrData = '0, pbLoadData = '0;
  logic        dbWrEn = 1'b0, pbLoadEn = 1'b0;
  logic [23:0] busAddr;
  logic        penaltyCycle;
  logic [7:0]  progBank, dataBank;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [7:0] pbModel = 8'h00, dbModel = 8'h00;

  always #10 clk = ~clk;

  eff_addr_gen u_dut (.*);

  function automatic logic [23:0] refAddr(logic [2:0] k, logic [7:0] pb, logic [7:0] db);
    logic [24:0] wide;
    case (k)
      3'd0: refAddr = {pb, 16'((32'(pcValue) + 32'(baseOffset)) % 65536)};
      3'd1: refAddr = {db, baseOffset};
      3'd2: begin
        wide = 25'(db) * 25'd65536 + 25'(baseOffset) + 25'(indexValue);
        refAddr = wide[23:0];
      end
      3'd3: refAddr = {longBank, baseOffset};
      3'd4: refAddr = {8'h00, 16'((32'(dpReg) + 32'(baseOffset[7:0])) % 65536)};
      3'd5: refAddr = {8'h00, 16'((32'(stackPtr) + 32'(baseOffset)) % 65536)};
      default: refAddr = 24'h0;
    endcase
  endfunction

  function automatic logic refPenalty(logic [2:0] k);
    return (k == 3'd4) && (dpReg[7:0] != 8'h00);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string kindReq(logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Drive at negedge, sample 1 ns later, well before the next rising edge.
  task automatic access(logic [2:0] k, logic [15:0] ofs, logic [15:0] idx);
    @(negedge clk);
    accessKind = k; baseOffset = ofs; indexValue = idx;
    #1;
    check(kindReq(k), busAddr, refAddr(k, pbModel, dbModel));
    check("R8", penaltyCycle, refPenalty(k));
  endtask

  task automatic writeDb(logic [7:0] v);
    @(negedge clk);
    dbWrEn = 1'b1; dbWrData = v;
    @(posedge clk); #1;
    dbWrEn = 1'b0;
    dbModel = v;
  endtask

  task automatic loadPb(logic [7:0] v);
    @(negedge clk);
    pbLoadEn = 1'b1; pbLoadData = v;
    @(posedge clk); #1;
    pbLoadEn = 1'b0;
    pbModel = v;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 reset state: write strobes are asserted during reset and must be ignored
    dbWrEn = 1'b1; dbWrData = 8'h55; pbLoadEn = 1'b1; pbLoadData = 8'h66;
    repeat (3) @(posedge clk);
    #1; dbWrEn = 1'b0; pbLoadEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", progBank, 8'h00);
    check("R1", dataBank, 8'h00);
    pcValue = 16'h1234;
    access(3'd0, 16'h0000, 16'h0);

    // R2 fetch wraps inside the program bank
    loadPb(8'h12);
    check("R9", progBank, 8'h12);
    pcValue = 16'hFFFF;
    access(3'd0, 16'h0001, 16'h0);
    check("R2", busAddr, 24'h120000);

    // R4 indexed carry moves to the next bank, the stored bank stays put
    writeDb(8'h12);
    access(3'd2, 16'hFFF0, 16'h0020);
    check("R4", busAddr, 24'h130010);
    check("R4", dataBank, 8'h12);
    writeDb(8'hFF);
    access(3'd2, 16'hFFFF, 16'h0002);
    check("R4", busAddr, 24'h000001);

    // R3 and R5: the long operand ignores the data bank
    access(3'd1, 16'hABCD, 16'h0);
    check("R3", busAddr, 24'hFFABCD);
    longBank = 8'h7E;
    access(3'd3, 16'h8000, 16'hFFFF);
    check("R5", busAddr, 24'h7E8000);

    // R6 and R8: the direct-page sum wraps in bank zero; penalty on an unaligned register
    dpReg = 16'hFFF0;
    access(3'd4, 16'hFF20, 16'h0);
    check("R6", busAddr, 24'h000010);
    check("R8", penaltyCycle, 1'b1);
    dpReg = 16'h1200;
    access(3'd4, 16'h0034, 16'h0);
    check("R8", penaltyCycle, 1'b0);

    // R7 stack wrap
    stackPtr = 16'hFFFF;
    access(3'd5, 16'h0002, 16'h0);
    check("R7", busAddr, 24'h000001);

    // R9 reserved kind codes
    access(3'd6, 16'h1234, 16'h1);
    access(3'd7, 16'h1234, 16'h1);

    // R9 same-cycle write and indexed carry: the old bank is used until the edge
    @(negedge clk);
    accessKind = 3'd2; baseOffset = 16'hFFFF; indexValue = 16'h0001;
    dbWrEn = 1'b1; dbWrData = 8'h40;
    #1;
    check("R9", busAddr, 24'h000000);
    @(posedge clk); #1;
    dbWrEn = 1'b0; dbModel = 8'h40;
    check("R9", busAddr, 24'h410000);

    // R9 same-cycle load and fetch
    @(negedge clk);
    accessKind = 3'd0; pcValue = 16'h0100; baseOffset = 16'h0;
    pbLoadEn = 1'b1; pbLoadData = 8'h03;
    #1;
    check("R9", busAddr, 24'h120100);
    @(posedge clk); #1;
    pbLoadEn = 1'b0; pbModel = 8'h03;
    check("R9", busAddr, 24'h030100);
    check("R9", dataBank, 8'h40);

    // randomized, biased toward the bank edge
    void'($urandom(32'd2024));
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] ofs, idx;
      ofs = ($urandom % 4 == 0) ? 16'hFFFF - 16'($urandom % 16) : 16'($urandom);
      idx = 16'($urandom);
      pcValue  = ($urandom % 2) ? 16'hFFFF - 16'($urandom % 8) : 16'($urandom);
      dpReg    = ($urandom % 3 == 0) ? {8'($urandom), 8'h00} : 16'($urandom);
      stackPtr = 16'($urandom);
      longBank = 8'($urandom);
      if (i % 50 == 0) writeDb(8'($urandom));
      if (i % 77 == 0) loadPb(8'($urandom));
      access(3'($urandom % 8), ofs, idx);
    end
    check("R9", dataBank, dbModel);
    check("R9", progBank, pbModel);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule